// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of subroutine returns for an instruction fetch unit. Each time fetch sees a call, it presents the address of the instruction that follows the call. The block stores that address on a small hardware stack. Each time fetch sees a return, the block removes the most recent stored address and offers it as the predicted target. The prediction comes out combinationally in the same cycle as the return strobe. The stack update takes effect at the next clock edge.

The stack is a circular buffer with a parameterised depth. When it is already full, a further call overwrites the oldest stored address, so fetch never stalls, and the occupancy count stays at the depth. When the branch unit finds that a return target was wrong, it pulses the flush input, and the whole stack is emptied at the next edge. A call and a return in the same cycle are ordered as pop first, then push. A return on an empty stack yields no valid prediction and leaves the stack untouched.

Top module: `ras_predictor`

## Requirements
- R1: A call (call_i high, flush_i low) stores call_addr_i as the new top entry. From the next cycle, a return reads that address on pred_target_o. If the stack was not full, occupancy_o rises by one.
- R2: A return (ret_i high) on a non-empty stack drives pred_valid_o high in that cycle, with pred_target_o equal to the most recently stored address that has not yet been popped. Without a call or flush, occupancy_o falls by one at the next edge.
- R3: A call while full overwrites the oldest entry. occupancy_o stays at DEPTH. Successive returns then give back the latest DEPTH addresses, newest first, and the following return is invalid.
- R4: A return while occupancy_o is 0 keeps pred_valid_o low, and the occupancy stays 0. Stored entries are unaffected.
- R5: A call and a return in the same cycle on a non-empty stack predict the old top entry. The new address then replaces that entry, and occupancy_o is unchanged.
- R6: A call and a return in the same cycle on an empty stack give pred_valid_o low. The occupancy then becomes 1, with the new address on top.
- R7: flush_i high empties the stack at the next edge (occupancy_o = 0), whatever the call and return inputs are in that cycle.
- R8: full_o is high exactly when occupancy_o equals DEPTH. empty_o is high exactly when occupancy_o is 0.
- R9: After reset, occupancy_o is 0, empty_o is high and full_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call fetched this cycle |
| call_addr_i | input | AW | Return address to store for the call |
| ret_i | input | 1 | Return fetched this cycle; requests a prediction |
| flush_i | input | 1 | Return target found wrong; empty the stack |
| pred_target_o | output | AW | Current top entry (predicted return target) |
| pred_valid_o | output | 1 | ret_i high and stack non-empty |
| occupancy_o | output | $clog2(DEPTH+1) | Number of stored entries |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |

## Verification
On every cycle, the assertions check the following:
- how the occupancy moves for a push, a pop, a combined push and pop, a saturating push and a flush;
- that the occupancy never exceeds DEPTH;
- that a pop on an empty stack never yields a valid prediction;
- that a call's address is on top one cycle later.

Only the bench's scenarios can show two things. The first is that entries deeper in the stack come back in last-in, first-out order. The second is that an overflowing call loses exactly the oldest address, so that a full drain returns the latest DEPTH addresses and then goes invalid. The bench compares the design against a bounded queue model over long mixed sequences of calls, returns and flushes on a depth-4 stack.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // circular index step forward, wrapping at depth
  function automatic int unsigned ras_step_up(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // circular index step backward, wrapping at depth
  function automatic int unsigned ras_step_down(input int unsigned idx, input int unsigned depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction

  // occupancy after an optional pop then an optional push, saturating at depth
  function automatic int unsigned ras_next_fill(input int unsigned fill, input bit pop,
                                                input bit push, input int unsigned depth);
    int unsigned after_pop;
    after_pop = (pop && fill != 0) ? fill - 1 : fill;
    if (!push) return after_pop;
    return (after_pop >= depth) ? depth : after_pop + 1;
  endfunction
endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic          flush_req,
  output logic          wr_en,
  output logic [PW-1:0] wr_slot,
  output logic [PW-1:0] top_slot,
  output logic [CW-1:0] fill,
  output logic          is_full,
  output logic          is_empty
);
  localparam logic [CW-1:0] FULL_FILL = CW'(DEPTH);

  logic [PW-1:0] head_q;     // next free slot
  logic [CW-1:0] fill_q;
  logic          pop_ev;     // named events for the assertions
  logic          push_ev;
  logic [PW-1:0] head_after_pop;
  logic [PW-1:0] head_d;
  logic [CW-1:0] fill_d;

  assign is_empty = (fill_q == '0);
  assign is_full  = (fill_q == FULL_FILL);
  assign fill     = fill_q;

  assign pop_ev  = ret_req && !is_empty && !flush_req;
  assign push_ev = call_req && !flush_req;

  always_comb begin
    head_after_pop = pop_ev ? PW'(ras_step_down(int'(head_q), DEPTH)) : head_q;
    head_d = push_ev ? PW'(ras_step_up(int'(head_after_pop), DEPTH)) : head_after_pop;
    fill_d = CW'(ras_next_fill(int'(fill_q), pop_ev, push_ev, DEPTH));
  end

  assign wr_en    = push_ev;
  assign wr_slot  = head_after_pop;
  assign top_slot = PW'(ras_step_down(int'(head_q), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n || flush_req) begin
      head_q <= '0;
      fill_q <= '0;
    end else begin
      head_q <= head_d;
      fill_q <= fill_d;
    end
  end

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL_FILL);
  p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !ret_req && !flush_req && !is_full) |=> fill_q == $past(fill_q) + 1'b1);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !ret_req && !flush_req && is_full) |=> is_full);
  p_pop_shrinks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && !flush_req && !is_empty) |=> fill_q == $past(fill_q) - 1'b1);
  p_empty_pop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && !flush_req && is_empty) |=> is_empty);
  p_swap_keeps_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && call_req && !flush_req && !is_empty) |=> $stable(fill_q));
  p_swap_on_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && call_req && !flush_req && is_empty) |=> fill_q == CW'(1));
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> is_empty);
  p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_full && is_empty));
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_slot,
  input  logic [AW-1:0] wr_data,
  input  logic [PW-1:0] rd_slot,
  output logic [AW-1:0] rd_data
);
  logic [AW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (wr_en && wr_slot == PW'(g)) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_slot];
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic [AW-1:0] call_addr_i,
  input  logic          ret_i,
  input  logic          flush_i,
  output logic [AW-1:0] pred_target_o,
  output logic          pred_valid_o,
  output logic [CW-1:0] occupancy_o,
  output logic          full_o,
  output logic          empty_o
);
  logic          wr_en;
  logic [PW-1:0] wr_slot;
  logic [PW-1:0] top_slot;
  logic [AW-1:0] top_entry;   // brought out for the assertions

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_req (call_i),
    .ret_req  (ret_i),
    .flush_req(flush_i),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .top_slot (top_slot),
    .fill     (occupancy_o),
    .is_full  (full_o),
    .is_empty (empty_o)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_slot(wr_slot),
    .wr_data(call_addr_i),
    .rd_slot(top_slot),
    .rd_data(top_entry)
  );

  assign pred_target_o = top_entry;
  assign pred_valid_o  = ret_i && !empty_o;

  p_call_on_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !flush_i) |=> top_entry == $past(call_addr_i));
  p_empty_no_pred_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && empty_o) |-> !pred_valid_o);
  p_pred_when_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !empty_o) |-> pred_valid_o);
endmodule

// File: tb/tb_ras_predictor.sv
`timescale 1ns/1ps
module tb_ras_predictor;
  localparam int TB_DEPTH = 4;
  localparam int TB_AW = 16;
  localparam int TB_CW = $clog2(TB_DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 1'b0;
  logic [TB_AW-1:0] call_addr_i = '0;
  logic ret_i = 1'b0;
  logic flush_i = 1'b0;
  logic [TB_AW-1:0] pred_target_o;
  logic pred_valid_o;
  logic [TB_CW-1:0] occupancy_o;
  logic full_o;
  logic empty_o;

  int checks = 0;
  int failures = 0;
  logic [TB_AW-1:0] model_q[$];

  always #2.5 clk = ~clk;

  ras_predictor #(.DEPTH(TB_DEPTH), .AW(TB_AW)) dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_addr_i(call_addr_i),
    .ret_i(ret_i), .flush_i(flush_i), .pred_target_o(pred_target_o),
    .pred_valid_o(pred_valid_o), .occupancy_o(occupancy_o),
    .full_o(full_o), .empty_o(empty_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_status(input string tag);
    int n;
    n = model_q.size();
    check(occupancy_o == TB_CW'(n), tag, "occupancy", occupancy_o, n);
    check(full_o == (n == TB_DEPTH), {tag, " R8"}, "full", full_o, n == TB_DEPTH);
    check(empty_o == (n == 0), {tag, " R8"}, "empty", empty_o, n == 0);
  endtask

  // one cycle: drive at negedge, check before the edge, update model after it
  task automatic step(input logic c, input logic [TB_AW-1:0] a, input logic r,
                      input logic f, input string tag);
    bit exp_v;
    @(negedge clk);
    call_i = c; call_addr_i = a; ret_i = r; flush_i = f;
    #1;
    exp_v = r && (model_q.size() > 0);
    check(pred_valid_o == exp_v, tag, "pred_valid", pred_valid_o, exp_v);
    if (exp_v)
      check(pred_target_o == model_q[$], tag, "pred_target", pred_target_o, model_q[$]);
    check_status(tag);
    @(posedge clk);
    if (f) model_q.delete();
    else begin
      if (r && model_q.size() > 0) void'(model_q.pop_back());
      if (c) begin
        model_q.push_back(a);
        if (model_q.size() > TB_DEPTH) void'(model_q.pop_front());
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state
    check(occupancy_o == '0, "R9", "occupancy", occupancy_o, 0);
    check(empty_o == 1'b1, "R9", "empty", empty_o, 1);
    check(full_o == 1'b0, "R9", "full", full_o, 0);

    // R4: pop on empty
    step(0, 16'h0, 1, 0, "R4");
    step(0, 16'h0, 0, 0, "R4");
    // R1 pushes, R2 pops in LIFO order
    for (int i = 1; i <= 3; i++) step(1, TB_AW'(16'h100 + i), 0, 0, "R1");
    for (int i = 0; i < 4; i++) step(0, 16'h0, 1, 0, "R2");
    step(0, 16'h0, 0, 0, "R2");
    // R3: overflow overwrites oldest, then full drain
    for (int i = 0; i < 7; i++) step(1, TB_AW'(16'h200 + i), 0, 0, "R3");
    for (int i = 0; i < 5; i++) step(0, 16'h0, 1, 0, "R3");
    // R6: call+return on empty
    step(1, 16'h3AA, 1, 0, "R6");
    step(0, 16'h0, 0, 0, "R6");
    // R5: call+return on non-empty and on full
    step(1, 16'h3BB, 0, 0, "R5");
    step(1, 16'h3CC, 1, 0, "R5");
    step(1, 16'h3DD, 0, 0, "R5");
    step(1, 16'h3EE, 0, 0, "R5");
    step(1, 16'h3FF, 1, 0, "R5");
    for (int i = 0; i < 5; i++) step(0, 16'h0, 1, 0, "R5");
    // R7: flush with call and return present
    step(1, 16'h401, 0, 0, "R7");
    step(1, 16'h402, 0, 0, "R7");
    step(1, 16'h403, 1, 1, "R7");
    step(0, 16'h0, 1, 0, "R7");
    step(0, 16'h0, 0, 0, "R7");

    // mixed sweep against the queue model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[0], rv[31:16], rv[1] & ~rv[8], rv[7:2] == 6'd0, "R2 R3 R5 sweep");
    end
    step(0, 16'h0, 0, 0, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule